// File: doc/BRIEF.md
# Age-Priority Crossbar Output Arbiter

This block decides, every clock cycle, which queued message heads may cross a switch crossbar. A request slot exists for each combination of input port, virtual channel and target output. A message that waits for one output therefore never hides a message from the same buffer that wants a different output. Each slot carries an 8-bit age, and a larger age means higher priority. The block grants at most one slot per output and at most one slot per input port. It builds the match greedily, oldest first, and keeps going until no free input can reach a free output.

While a request is resident, its age grows by one every programmable number of cycles. Ordinary traffic saturates at 239. Ages 240 to 255 belong to traffic that was injected as urgent, and those ages never change. The age of each granted slot is presented per output so that it can be written into the outgoing header.

A granted message that has not yet sent its tail holds its output. Only a request on another virtual channel that is older than both the holder and a programmable cut-through threshold can take that output away. When no output and no input sees more than one eligible request, a fixed-priority bypass grants every eligible request directly.

Top module: `age_xbar_arbiter`

Per-output lock state machine: states `OUT_FREE` and `OUT_HELD`. The transitions are:
- ACQUIRE (`OUT_FREE` to `OUT_HELD`): a grant on a micropacket that is not a tail.
- RELEASE (`OUT_HELD` to `OUT_FREE`): a grant on a tail, or the holder's request withdrawn with no other grant.
- HANDOVER (`OUT_HELD` to `OUT_HELD`, new holder): a non-tail grant to a cut-through challenger, or the holder's own continued non-tail grant.

## Requirements
- R1: After reset, `grant` is zero and `out_age` is zero when no request is valid, every output is in `OUT_FREE`, the tie pointer is at input 0 and the stored ages are zero.
- R2: Slot index is `(in*NVC + vc)*NOUT + out`. At most one slot per output is granted in a cycle, and only slots with `req_valid` high are granted.
- R3: At most one slot per input port is granted in a cycle, whatever its virtual channel or output.
- R4: Among eligible requests for a free output, the one with the larger current age is granted.
- R5: The match is maximal: after granting, no eligible request remains whose input port and output are both unassigned.
- R6: Equal keys are resolved by a rotating pointer. Input `(ptr+k) mod NIN` ranks above input `(ptr+k+1) mod NIN`. After any cycle with a grant, the pointer moves to one past the input of the highest-ranked winner. Within one input, the lower slot index wins.
- R7: `req_new` loads `req_age` into the slot, and that value takes effect in the same cycle. A valid slot then gains one age step every `age_period` cycles; `age_period` 0 stops aging. `out_age` gives the current age of the slot granted on each output.
- R8: A stored age below 240 never rises above 239.
- R9: A stored age of 240 to 255 stays unchanged until the slot is reloaded.
- R10: A non-tail grant locks the output to that slot. While the holder stays valid, other requests on the same virtual channel are not granted that output. The lock ends after a tail grant, or as soon as the holder drops `req_valid`.
- R11: A request on a locked output that is on a different virtual channel than the holder, and whose age is above both `cut_thresh` and the holder's age, takes the output and becomes the new holder. Same-channel requests never do this.
- R12: `bypass` is high exactly when no output and no input port has more than one eligible request. In that case every eligible request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NIN*NVC*NOUT | Slot holds a waiting head micropacket |
| req_new | input | NIN*NVC*NOUT | A new message head enters the slot; loads its age |
| req_tail | input | NIN*NVC*NOUT | The slot's current micropacket ends its message |
| req_age | input | NIN*NVC*NOUT*8 | Header age for slots loading this cycle |
| age_period | input | 8 | Cycles per age step; 0 disables aging |
| cut_thresh | input | 8 | Age that must be exceeded to cut through a held output |
| grant | output | NIN*NVC*NOUT | Granted slots this cycle |
| out_age | output | NOUT*8 | Current age of the slot granted on each output, 0 if none |
| bypass | output | 1 | Conflict-free cycle served by the direct path |

## Verification
The hardest case to reach is a handover, where an output held by an unfinished message is taken over by a cut-through challenger. The stimulus first acquires the output with a non-tail grant. It then offers an old challenger on the same virtual channel, which must be refused. Finally it offers a challenger on the other channel, which must win, and in the next cycle the stimulus confirms that this challenger now owns the lock by keeping the old holder valid and seeing it still lose. Greedy maximality is checked with a pattern where the oldest request blocks a younger request from the same input, so a third input must pick up the remaining output.

// File: rtl/age_arb_pkg.sv
`timescale 1ns/1ps
package age_arb_pkg;
    localparam int          AGE_W    = 8;
    localparam logic [7:0]  AGE_CAP  = 8'd239;
    localparam logic [7:0]  HI_FLOOR = 8'd240;

    typedef enum logic {
        OUT_FREE = 1'b0,
        OUT_HELD = 1'b1
    } out_state_e;
endpackage

// File: rtl/arb_age_slot.sv
`timescale 1ns/1ps
module arb_age_slot
    import age_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             load,
    input  logic             tick,
    input  logic [AGE_W-1:0] load_age,
    output logic [AGE_W-1:0] age_q,
    output logic [AGE_W-1:0] age_eff
);
    logic [AGE_W-1:0] age_r;

    // Saturating age; values at or above HI_FLOOR never satisfy the compare
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_r <= '0;
        else if (load)
            age_r <= load_age;
        else if (valid && tick && age_r < AGE_CAP)
            age_r <= age_r + 1'b1;
    end

    assign age_q   = age_r;
    assign age_eff = load ? load_age : age_r;
endmodule

// File: rtl/arb_out_lock.sv
`timescale 1ns/1ps
module arb_out_lock
    import age_arb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_any,
    input  logic [IDX_W-1:0] gnt_idx,
    input  logic             gnt_tail,
    input  logic             owner_valid,
    output logic             held,
    output logic [IDX_W-1:0] owner
);
    out_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            OUT_FREE: begin
                if (gnt_any && !gnt_tail) begin      // ACQUIRE
                    state_d = OUT_HELD;
                    owner_d = gnt_idx;
                end
            end
            OUT_HELD: begin
                if (gnt_any) begin                   // RELEASE or HANDOVER
                    state_d = gnt_tail ? OUT_FREE : OUT_HELD;
                    owner_d = gnt_idx;
                end else if (!owner_valid) begin     // RELEASE on withdrawal
                    state_d = OUT_FREE;
                end
            end
        endcase
    end

    assign held  = (state_q == OUT_HELD);
    assign owner = owner_q;
endmodule

// File: rtl/arb_greedy_match.sv
`timescale 1ns/1ps
module arb_greedy_match #(
    parameter int NIN   = 3,
    parameter int NVC   = 2,
    parameter int NOUT  = 3,
    parameter int KEY_W = 11,
    localparam int NREQ = NIN * NVC * NOUT,
    localparam int IN_W = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic [NREQ-1:0]             cand,
    input  logic [NREQ-1:0][KEY_W-1:0]  key,
    output logic [NREQ-1:0]             grant,
    output logic [IN_W-1:0]             first_in
);
    logic [NIN-1:0]  in_busy;
    logic [NOUT-1:0] out_busy;

    // One pass per output: pick the strongest request on a free input and free output
    always_comb begin
        in_busy  = '0;
        out_busy = '0;
        grant    = '0;
        first_in = '0;
        for (int k = 0; k < NOUT; k++) begin
            logic             found;
            int               best;
            logic [KEY_W-1:0] bkey;
            found = 1'b0;
            best  = 0;
            bkey  = '0;
            for (int r = 0; r < NREQ; r++) begin
                if (cand[r] && !in_busy[r / (NVC * NOUT)] && !out_busy[r % NOUT]) begin
                    if (!found || key[r] > bkey) begin
                        found = 1'b1;
                        best  = r;
                        bkey  = key[r];
                    end
                end
            end
            if (found) begin
                grant[best]                  = 1'b1;
                in_busy[best / (NVC * NOUT)] = 1'b1;
                out_busy[best % NOUT]        = 1'b1;
                if (k == 0)
                    first_in = IN_W'(best / (NVC * NOUT));
            end
        end
    end
endmodule

// File: rtl/age_xbar_arbiter.sv
`timescale 1ns/1ps
module age_xbar_arbiter
    import age_arb_pkg::*;
#(
    parameter int NIN   = 3,
    parameter int NVC   = 2,
    parameter int NOUT  = 3,
    parameter int PER_W = 8,
    localparam int NREQ  = NIN * NVC * NOUT,
    localparam int IDX_W = $clog2(NREQ),
    localparam int IN_W  = (NIN > 1) ? $clog2(NIN) : 1,
    localparam int KEY_W = 1 + AGE_W + IN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREQ-1:0]       req_valid,
    input  logic [NREQ-1:0]       req_new,
    input  logic [NREQ-1:0]       req_tail,
    input  logic [NREQ*AGE_W-1:0] req_age,
    input  logic [PER_W-1:0]      age_period,
    input  logic [AGE_W-1:0]      cut_thresh,
    output logic [NREQ-1:0]       grant,
    output logic [NOUT*AGE_W-1:0] out_age,
    output logic                  bypass
);
    logic [PER_W-1:0]             tick_cnt;
    logic                         tick;
    logic [NREQ-1:0][AGE_W-1:0]   age_eff;
    logic [NREQ*AGE_W-1:0]        slot_age_q;
    logic [IN_W-1:0]              rr_ptr;
    logic [NOUT-1:0]              held;
    logic [NOUT-1:0][IDX_W-1:0]   owner;
    logic [NOUT-1:0]              owner_valid;
    logic [NOUT-1:0]              gnt_any, gnt_tail;
    logic [NOUT-1:0][IDX_W-1:0]   gnt_idx;
    logic [NREQ-1:0]              cand;
    logic [NREQ-1:0][KEY_W-1:0]   key;
    logic [NREQ-1:0]              match_grant;
    logic [IN_W-1:0]              first_in;

    // Aging prescaler
    assign tick = (age_period != '0) && (tick_cnt >= age_period - 1'b1);
    always_ff @(posedge clk) begin
        if (!rst_n || tick || age_period == '0)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + 1'b1;
    end

    for (genvar s = 0; s < NREQ; s++) begin : g_slot
        arb_age_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (req_valid[s]),
            .load     (req_new[s]),
            .tick     (tick),
            .load_age (req_age[s*AGE_W +: AGE_W]),
            .age_q    (slot_age_q[s*AGE_W +: AGE_W]),
            .age_eff  (age_eff[s])
        );
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_lock
        assign owner_valid[o] = req_valid[owner[o]];
        arb_out_lock #(.IDX_W(IDX_W)) u_lock (
            .clk         (clk),
            .rst_n       (rst_n),
            .gnt_any     (gnt_any[o]),
            .gnt_idx     (gnt_idx[o]),
            .gnt_tail    (gnt_tail[o]),
            .owner_valid (owner_valid[o]),
            .held        (held[o]),
            .owner       (owner[o])
        );
    end

    // Eligibility and priority key {hold/cut-through, age, rotated rank}
    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            int   o, w, rank;
            logic live, chal;
            o    = r % NOUT;
            w    = int'(owner[o]);
            live = held[o] && owner_valid[o];
            chal = req_valid[r] && (age_eff[r] > cut_thresh) && (age_eff[r] > age_eff[w])
                   && (((r / NOUT) % NVC) != ((w / NOUT) % NVC));
            rank = (r / (NVC * NOUT) + NIN - int'(rr_ptr)) % NIN;
            if (!live) begin
                cand[r] = req_valid[r];
                key[r]  = {1'b0, age_eff[r], IN_W'(NIN - 1 - rank)};
            end else if (r == w) begin
                cand[r] = req_valid[r];
                key[r]  = {1'b1, age_eff[r], IN_W'(NIN - 1 - rank)};
            end else begin
                cand[r] = chal;
                key[r]  = {chal, age_eff[r], IN_W'(NIN - 1 - rank)};
            end
        end
    end

    arb_greedy_match #(.NIN(NIN), .NVC(NVC), .NOUT(NOUT), .KEY_W(KEY_W)) u_match (
        .cand     (cand),
        .key      (key),
        .grant    (match_grant),
        .first_in (first_in)
    );

    // Conflict detection for the direct path
    always_comb begin
        int ocnt [NOUT];
        int icnt [NIN];
        for (int o = 0; o < NOUT; o++) ocnt[o] = 0;
        for (int i = 0; i < NIN; i++)  icnt[i] = 0;
        for (int r = 0; r < NREQ; r++) begin
            if (cand[r]) begin
                ocnt[r % NOUT]         = ocnt[r % NOUT] + 1;
                icnt[r / (NVC * NOUT)] = icnt[r / (NVC * NOUT)] + 1;
            end
        end
        bypass = 1'b1;
        for (int o = 0; o < NOUT; o++) if (ocnt[o] > 1) bypass = 1'b0;
        for (int i = 0; i < NIN; i++)  if (icnt[i] > 1) bypass = 1'b0;
    end

    assign grant = bypass ? cand : match_grant;

    always_comb begin
        gnt_any  = '0;
        gnt_tail = '0;
        gnt_idx  = '0;
        out_age  = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (grant[r]) begin
                gnt_any[r % NOUT]                 = 1'b1;
                gnt_idx[r % NOUT]                 = IDX_W'(r);
                gnt_tail[r % NOUT]                = req_tail[r];
                out_age[(r % NOUT)*AGE_W +: AGE_W] = age_eff[r];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (|grant)
            rr_ptr <= (int'(first_in) == NIN - 1) ? '0 : first_in + 1'b1;
    end
endmodule

// File: rtl/age_xbar_arbiter_chk.sv
`timescale 1ns/1ps
module age_xbar_arbiter_chk #(
    parameter int NIN  = 3,
    parameter int NVC  = 2,
    parameter int NOUT = 3,
    localparam int NREQ = NIN * NVC * NOUT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req_valid,
    input logic [NREQ-1:0]   req_new,
    input logic [NREQ-1:0]   grant,
    input logic [NREQ*8-1:0] slot_age_q
);
    logic [NOUT-1:0][NIN*NVC-1:0] per_out;

    always_comb begin
        for (int o = 0; o < NOUT; o++)
            for (int j = 0; j < NIN * NVC; j++)
                per_out[o][j] = grant[j * NOUT + o];
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        assert_out_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(per_out[o]));
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        assert_in_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[i*NVC*NOUT +: NVC*NOUT]));
    end

    assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);

    for (genvar s = 0; s < NREQ; s++) begin : g_age
        assert_age_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_new[s] && slot_age_q[s*8 +: 8] <= 8'd239) |=> (slot_age_q[s*8 +: 8] <= 8'd239));
        assert_age_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_new[s] && slot_age_q[s*8 +: 8] >= 8'd240) |=> $stable(slot_age_q[s*8 +: 8]));
    end
endmodule

bind age_xbar_arbiter age_xbar_arbiter_chk #(.NIN(NIN), .NVC(NVC), .NOUT(NOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_new    (req_new),
    .grant      (grant),
    .slot_age_q (slot_age_q)
);

// File: tb/age_xbar_arbiter_bench.sv
`timescale 1ns/1ps
module age_xbar_arbiter_bench;
    localparam int NIN = 3, NVC = 2, NOUT = 3;
    localparam int NREQ = NIN * NVC * NOUT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NREQ-1:0]   req_valid, req_new, req_tail;
    logic [NREQ*8-1:0] req_age;
    logic [7:0]        age_period, cut_thresh;
    logic [NREQ-1:0]   grant;
    logic [NOUT*8-1:0] out_age;
    logic              bypass;
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    age_xbar_arbiter u_age_xbar_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_new(req_new),
        .req_tail(req_tail), .req_age(req_age), .age_period(age_period),
        .cut_thresh(cut_thresh), .grant(grant), .out_age(out_age), .bypass(bypass)
    );

    function automatic int sl(int i, int v, int o);
        return (i * NVC + v) * NOUT + o;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(int s, int age, bit tail);
        req_valid[s] = 1'b1;
        req_new[s]   = 1'b1;
        req_tail[s]  = tail;
        req_age[s*8 +: 8] = age[7:0];
    endtask

    task automatic step();
        @(negedge clk);
        req_new = '0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0; req_new = '0; req_tail = '0; req_age = '0;
        age_period = 8'd0; cut_thresh = 8'd255;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(); settle();
        chk("R1 grant after reset", grant, 0);
        chk("R1 out_age after reset", out_age, 0);
        chk("R12 bypass idle", bypass, 1);
    endtask

    task automatic t_bypass();
        do_reset();
        put(sl(0,0,0), 3, 1); put(sl(1,1,1), 4, 1); put(sl(2,0,2), 5, 1);
        settle();
        chk("R12 bypass grants all", grant, 18'h04401);
        chk("R12 bypass flag", bypass, 1);
    endtask

    task automatic t_age_order();
        do_reset();
        put(sl(0,0,0), 10, 1); put(sl(1,0,0), 50, 1);
        settle();
        chk("R4 older wins", grant, 18'h00040);
        chk("R12 no bypass on conflict", bypass, 0);
        chk("R7 out_age of winner", out_age[7:0], 50);
        step();
        put(sl(0,0,0), 60, 1);
        settle();
        chk("R4 older wins swapped", grant, 18'h00001);
    endtask

    task automatic t_maximal();
        do_reset();
        put(sl(0,0,0), 90, 1); put(sl(0,0,1), 80, 1);
        put(sl(1,0,1), 70, 1); put(sl(2,0,0), 60, 1);
        settle();
        chk("R5 R3 maximal match", grant, 18'h00081);
        chk("R5 out1 age", out_age[15:8], 70);
    endtask

    task automatic t_tie();
        do_reset();
        put(sl(0,0,0), 20, 1); put(sl(1,0,0), 20, 1);
        settle();
        chk("R6 tie first input0", grant, 18'h00001);
        step(); settle();
        chk("R6 tie rotates to input1", grant, 18'h00040);
        step(); settle();
        chk("R6 tie wraps to input0", grant, 18'h00001);
    endtask

    task automatic t_aging();
        do_reset();
        age_period = 8'd1;
        put(sl(0,0,0), 5, 1);
        settle();
        chk("R7 loaded age visible", out_age[7:0], 5);
        for (int i = 0; i < 4; i++) step();
        settle();
        chk("R7 period1 aging", out_age[7:0], 8);
        do_reset();
        age_period = 8'd0;
        put(sl(0,0,0), 9, 1);
        for (int i = 0; i < 4; i++) step();
        settle();
        chk("R7 period0 no aging", out_age[7:0], 9);
        do_reset();
        age_period = 8'd2;
        put(sl(0,0,0), 9, 1);
        step(); settle();
        chk("R7 period2 start", out_age[7:0], 9);
        for (int i = 0; i < 4; i++) step();
        settle();
        chk("R7 period2 two steps", out_age[7:0], 11);
    endtask

    task automatic t_cap();
        do_reset();
        age_period = 8'd1;
        put(sl(0,0,0), 237, 1);
        for (int i = 0; i < 6; i++) step();
        settle();
        chk("R8 saturates at 239", out_age[7:0], 239);
        do_reset();
        age_period = 8'd1;
        put(sl(0,0,0), 245, 1);
        for (int i = 0; i < 6; i++) step();
        settle();
        chk("R9 high age frozen", out_age[7:0], 245);
    endtask

    task automatic t_lock();
        do_reset();
        put(sl(0,0,1), 10, 0);
        settle();
        chk("R10 acquire", grant, 18'h00002);
        step();
        put(sl(1,0,1), 200, 1);
        settle();
        chk("R10 held against older", grant, 18'h00002);
        step();
        req_tail[sl(0,0,1)] = 1'b1;
        settle();
        chk("R10 tail still holder", grant, 18'h00002);
        step();
        req_valid[sl(0,0,1)] = 1'b0;
        settle();
        chk("R10 released to waiter", grant, 18'h00080);
    endtask

    task automatic t_cut();
        do_reset();
        cut_thresh = 8'd100;
        put(sl(0,0,1), 10, 0);
        settle();
        chk("R11 holder acquires", grant, 18'h00002);
        step();
        put(sl(1,0,1), 200, 1);
        settle();
        chk("R11 same channel refused", grant, 18'h00002);
        step();
        req_valid[sl(1,0,1)] = 1'b0;
        put(sl(1,1,1), 200, 0);
        settle();
        chk("R11 other channel cuts through", grant, 18'h00400);
        step(); settle();
        chk("R11 challenger now holds", grant, 18'h00400);
        chk("R11 out age of new holder", out_age[15:8], 200);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        req_valid = '0; req_new = '0; req_tail = '0; req_age = '0;
        age_period = 8'd0; cut_thresh = 8'd255;
        t_reset();
        t_bypass();
        t_age_order();
        t_maximal();
        t_tie();
        t_aging();
        t_cap();
        t_lock();
        t_cut();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule